// File: doc/BRIEF.md
# Inter-Processor Block/Unblock Wake Latch

This block sits beside one core of a multiprocessor cluster and turns two reserved no-op encodings into a low-power rendezvous. When the core retires the "block" encoding, it parks the core by raising a stall. The stall stays up until some core in the cluster signals "unblock" or an interrupt becomes pending. When the core retires the "unblock" encoding, the block sends a one-cycle broadcast that the cluster wiring fans out to the unblock inputs of every core.

A pending latch remembers any unblock seen since this core last completed a block. If the latch is set, the next block completes without idling. The core's own unblock is fed back into its own latch, so a core that signals and then blocks does not sleep. An unblock that arrives in the same cycle as a block counts as pending, so no wakeup can slip between the two.

When the extension is disabled by parameter, both encodings behave as plain no-ops.

Top module: `core_wake_latch`

## Requirements
- R1: After reset, and whenever `rstN` is driven low (even while idling), `stall` and `unblockBcast` are 0 and the pending latch is clear. A first block after reset therefore idles.
- R2: A retired block word 0x00002033 (slt x0,x0,x0) with no pending unblock raises `stall` on the next cycle. `stall` then stays high for as long as no unblock line and no interrupt is seen.
- R3: While idling, any bit of `unblockLines` being high lowers `stall` on the following cycle.
- R4: While idling, `irqPending` high lowers `stall` on the following cycle.
- R5: An unblock line seen while the core is running (not idling) sets the pending latch. The next block then completes with `stall` staying 0.
- R6: An unblock line that is high in the same cycle that a block retires makes that block fall through, with `stall` staying 0.
- R7: A retired unblock word 0x00102033 (slt x0,x0,x1) pulses `unblockBcast` high for exactly the next cycle. It also sets this core's own pending latch, so its next block falls through.
- R8: Completing a block, whether it fell through or was woken, clears the pending latch, so the block after it idles again.
- R9: Retire strobes presented while `stall` is high are ignored: no broadcast is sent and the core stays idle.
- R10: With `EXT_EN` = 0, both encodings act as no-ops: `stall` and `unblockBcast` stay 0.
- R11: Any other retired word, including slt x0,x0,x2 (0x00202033), neither stalls, broadcasts, nor sets the pending latch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| retireValid | input | 1 | An instruction retires this cycle |
| retireWord | input | INSTR_W | Encoding of the retiring instruction |
| irqPending | input | 1 | An interrupt is pending for this core |
| unblockLines | input | NUM_CORES | Unblock broadcasts from every core in the cluster |
| stall | output | 1 | Core is idling in block |
| unblockBcast | output | 1 | One-cycle unblock broadcast to the cluster |

## Verification
The bench targets lost wakeups in several ways:
- It sends an unblock in the same cycle as the block. A design that sampled only the registered latch would sleep forever there.
- It sends an unblock well before the block. A design without the latch would also sleep there.
- It has the core unblock itself. A design that forgot the self-reflection would idle.

It then blocks twice in a row to catch a latch that is never cleared, which would leave every later block falling through. It retires unblock while stalled, to catch a design that broadcasts from a parked core. It also retires near-miss encodings and uses an extension-disabled instance, to catch decoders that match too loosely.

// File: rtl/wake_pkg.sv
package wake_pkg;
  localparam logic [31:0] BLOCK_WORD   = 32'h0000_2033;
  localparam logic [31:0] UNBLOCK_WORD = 32'h0010_2033;

  typedef enum logic {ST_RUN = 1'b0, ST_IDLE = 1'b1} wakeState_t;

  typedef struct packed {
    logic consume;
    logic bcast;
  } wakeStrobes_t;
endpackage

// File: rtl/wake_decode.sv
module wake_decode #(
  parameter int INSTR_W = 32,
  parameter bit EXT_EN  = 1'b1
) (
  input  logic               retireValid,
  input  logic [INSTR_W-1:0] retireWord,
  output logic               isBlock,
  output logic               isUnblock
);
  import wake_pkg::*;

  generate
    if (EXT_EN) begin : g_ext
      always_comb begin
        isBlock   = retireValid && (retireWord == INSTR_W'(BLOCK_WORD));
        isUnblock = retireValid && (retireWord == INSTR_W'(UNBLOCK_WORD));
      end
    end else begin : g_noext
      // extension absent: both encodings are ordinary no-ops
      logic unusedIn;
      assign unusedIn  = retireValid ^ (^retireWord);
      assign isBlock   = 1'b0;
      assign isUnblock = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/wake_ctrl.sv
module wake_ctrl (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   isBlock,
  input  logic                   isUnblock,
  input  logic                   irqPending,
  input  logic                   anyUnblock,
  input  logic                   pendingNow,
  output wake_pkg::wakeStrobes_t strobes,
  output logic                   stall
);
  import wake_pkg::*;

  wakeState_t stateQ, stateD;
  logic blockGo, unblockGo, wakeNow;

  always_comb begin
    blockGo   = isBlock   && (stateQ == ST_RUN);
    unblockGo = isUnblock && (stateQ == ST_RUN);
    wakeNow   = anyUnblock || irqPending;
    stateD    = stateQ;
    case (stateQ)
      ST_RUN:  if (blockGo && !pendingNow) stateD = ST_IDLE;
      ST_IDLE: if (wakeNow) stateD = ST_RUN;
      default: stateD = ST_RUN;
    endcase
    strobes.consume = (blockGo && pendingNow) || ((stateQ == ST_IDLE) && wakeNow);
    strobes.bcast   = unblockGo;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_RUN;
    else       stateQ <= stateD;
  end

  assign stall = (stateQ == ST_IDLE);

  assert_line_wake_R3: assert property (@(posedge clk) disable iff (!rstN)
    (stall && anyUnblock) |=> !stall);
  assert_irq_wake_R4: assert property (@(posedge clk) disable iff (!rstN)
    (stall && irqPending) |=> !stall);
  assert_stall_needs_block_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stall) |-> $past(isBlock));
  assert_no_sleep_when_pending_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!stall && isBlock && pendingNow) |=> !stall);
endmodule

// File: rtl/wake_datapath.sv
module wake_datapath #(
  parameter int NUM_CORES = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_CORES-1:0]   unblockLines,
  input  wake_pkg::wakeStrobes_t strobes,
  output logic                   anyUnblock,
  output logic                   pendingNow,
  output logic                   unblockBcast
);
  logic pendingQ, bcastQ;

  assign anyUnblock = |unblockLines;
  // same-cycle arrival counts as pending
  assign pendingNow = pendingQ || anyUnblock;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendingQ <= 1'b0;
      bcastQ   <= 1'b0;
    end else begin
      bcastQ <= strobes.bcast;
      if (strobes.consume) pendingQ <= 1'b0;
      else if (anyUnblock || strobes.bcast) pendingQ <= 1'b1;
    end
  end

  assign unblockBcast = bcastQ;

  assert_consume_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.consume |=> !pendingQ);
  assert_line_latched_R5: assert property (@(posedge clk) disable iff (!rstN)
    (anyUnblock && !strobes.consume) |=> pendingQ);
  assert_self_reflect_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.bcast |=> (pendingQ && unblockBcast));
  assert_bcast_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.bcast |=> !unblockBcast);
endmodule

// File: rtl/core_wake_latch.sv
module core_wake_latch #(
  parameter int NUM_CORES = 4,
  parameter int INSTR_W   = 32,
  parameter bit EXT_EN    = 1'b1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 retireValid,
  input  logic [INSTR_W-1:0]   retireWord,
  input  logic                 irqPending,
  input  logic [NUM_CORES-1:0] unblockLines,
  output logic                 stall,
  output logic                 unblockBcast
);
  import wake_pkg::*;

  logic isBlock, isUnblock, anyUnblock, pendingNow;
  wakeStrobes_t strobes;

  wake_decode #(.INSTR_W(INSTR_W), .EXT_EN(EXT_EN)) u_decode (
    .retireValid(retireValid), .retireWord(retireWord),
    .isBlock(isBlock), .isUnblock(isUnblock)
  );

  wake_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .isBlock(isBlock), .isUnblock(isUnblock),
    .irqPending(irqPending), .anyUnblock(anyUnblock), .pendingNow(pendingNow),
    .strobes(strobes), .stall(stall)
  );

  wake_datapath #(.NUM_CORES(NUM_CORES)) u_dp (
    .clk(clk), .rstN(rstN), .unblockLines(unblockLines), .strobes(strobes),
    .anyUnblock(anyUnblock), .pendingNow(pendingNow), .unblockBcast(unblockBcast)
  );

  assert_parked_silent_R9: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> !unblockBcast);
endmodule

// File: tb/tb_core_wake_latch.sv
`timescale 1ns/1ps
module tb_core_wake_latch;
  localparam int NC = 4;
  localparam logic [31:0] W_BLK  = 32'h0000_2033;
  localparam logic [31:0] W_UNB  = 32'h0010_2033;
  localparam logic [31:0] W_NEAR = 32'h0020_2033;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic retireValid = 1'b0;
  logic [31:0] retireWord = '0;
  logic irqPending = 1'b0;
  logic [NC-1:0] unblockLines = '0;
  logic stall, unblockBcast, stallNop, bcastNop;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  core_wake_latch #(.NUM_CORES(NC)) dut (
    .clk(clk), .rstN(rstN), .retireValid(retireValid), .retireWord(retireWord),
    .irqPending(irqPending), .unblockLines(unblockLines),
    .stall(stall), .unblockBcast(unblockBcast));

  core_wake_latch #(.NUM_CORES(NC), .EXT_EN(1'b0)) dutNop (
    .clk(clk), .rstN(rstN), .retireValid(retireValid), .retireWord(retireWord),
    .irqPending(irqPending), .unblockLines(unblockLines),
    .stall(stallNop), .unblockBcast(bcastNop));

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  // drive for one cycle at a negedge, return at the next negedge with inputs idle
  task automatic cyc(input logic v, input logic [31:0] w, input logic irq, input logic [NC-1:0] l);
    retireValid = v; retireWord = w; irqPending = irq; unblockLines = l;
    @(negedge clk);
    retireValid = 1'b0; retireWord = '0; irqPending = 1'b0; unblockLines = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    rstN = 1'b0; idle(2); rstN = 1'b1; idle(1);
    check("R1 stall after reset", stall, 1'b0);
    check("R1 bcast after reset", unblockBcast, 1'b0);
    cyc(1'b1, W_BLK, 1'b0, '0);
    check("R1 first block idles (latch clear)", stall, 1'b1);
    rstN = 1'b0; #1;
    check("R1 reset while idle drops stall", stall, 1'b0);
    @(negedge clk); rstN = 1'b1; idle(1);
  endtask

  task automatic t_line_wake();
    cyc(1'b1, W_BLK, 1'b0, '0);
    check("R2 stall after block", stall, 1'b1);
    idle(4);
    check("R2 stall held without wake", stall, 1'b1);
    cyc(1'b0, '0, 1'b0, 4'b0010);
    check("R3 line wakes", stall, 1'b0);
    cyc(1'b1, W_BLK, 1'b0, '0);
    check("R8 latch clear after woken block", stall, 1'b1);
    cyc(1'b0, '0, 1'b1, '0);
    check("R4 irq wakes", stall, 1'b0);
  endtask

  task automatic t_pending();
    cyc(1'b0, '0, 1'b0, 4'b1000);
    idle(3);
    cyc(1'b1, W_BLK, 1'b0, '0);
    check("R5 earlier unblock makes block fall through", stall, 1'b0);
    cyc(1'b1, W_BLK, 1'b0, '0);
    check("R8 second block idles", stall, 1'b1);
    cyc(1'b0, '0, 1'b1, '0);
    cyc(1'b1, W_BLK, 1'b0, 4'b0100);
    check("R6 same-cycle unblock falls through", stall, 1'b0);
    cyc(1'b1, W_BLK, 1'b0, '0);
    check("R8 block after R6 idles", stall, 1'b1);
    cyc(1'b0, '0, 1'b1, '0);
  endtask

  task automatic t_self();
    cyc(1'b1, W_UNB, 1'b0, '0);
    check("R7 bcast pulse", unblockBcast, 1'b1);
    check("R7 no stall on unblock", stall, 1'b0);
    idle(1);
    check("R7 bcast one cycle", unblockBcast, 1'b0);
    cyc(1'b1, W_BLK, 1'b0, '0);
    check("R7 self reflection falls through", stall, 1'b0);
  endtask

  task automatic t_parked();
    cyc(1'b1, W_BLK, 1'b0, '0);
    cyc(1'b1, W_UNB, 1'b0, '0);
    check("R9 no bcast while stalled", unblockBcast, 1'b0);
    check("R9 still idle", stall, 1'b1);
    idle(1);
    check("R9 still idle later", stall, 1'b1);
    cyc(1'b0, '0, 1'b1, '0);
    cyc(1'b1, W_BLK, 1'b0, '0);
    check("R9 ignored unblock left latch clear", stall, 1'b1);
    cyc(1'b0, '0, 1'b1, '0);
  endtask

  task automatic t_other();
    cyc(1'b1, W_NEAR, 1'b0, '0);
    check("R11 near word no bcast", unblockBcast, 1'b0);
    check("R11 near word no stall", stall, 1'b0);
    cyc(1'b0, W_BLK, 1'b0, '0);
    check("R11 block word without retire ignored", stall, 1'b0);
    cyc(1'b1, W_BLK, 1'b0, '0);
    check("R11 latch untouched", stall, 1'b1);
    cyc(1'b0, '0, 1'b1, '0);
  endtask

  task automatic t_noext();
    cyc(1'b1, W_BLK, 1'b0, '0);
    check("R10 nop instance no stall", stallNop, 1'b0);
    cyc(1'b0, '0, 1'b1, '0);
    cyc(1'b1, W_UNB, 1'b0, '0);
    check("R10 nop instance no bcast", bcastNop, 1'b0);
    idle(1);
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_line_wake();
    t_pending();
    t_self();
    t_parked();
    t_other();
    t_noext();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule